// File: doc/BRIEF.md
# Serial EEPROM Command Sequencer

This block sits between a host and a byte-addressed serial EEPROM on a four-wire SPI bus. The host issues one of three requests: read a run of bytes from an address, write a run of bytes to an address, or fetch the device status byte. The sequencer turns each request into the instruction frames the device expects and drives the bus itself in mode 0, eight bits per frame, most significant bit first, with an active-low chip select framing every transaction.

Write payload arrives on a byte stream with valid/ready handshakes, and read payload and status bytes leave on a second stream of the same kind. The sequencer places a write-enable transaction ahead of every write transaction. It cuts a write into one transaction per 64-byte page, so that the device's six-bit page counter never wraps. After each write transaction it polls the status byte until the device finishes its self-timed programming cycle. While a request is in progress the busy flag is high. A one-cycle done pulse marks its completion.

When the host applies backpressure on the streams, the serial clock pauses between frames. The chip select stays low during such a pause, so the device keeps its place.

Top module: `spi_rom_cmd_seq`

## Requirements
- R1: While `csN` is high, `sclk` is low. `mosi` changes only while `sclk` is low, and every frame is sent and received most significant bit first.
- R2: A read request produces one transaction made of instruction 0x03, then an address high byte holding zeros above bit 5 with address bits 13..8 below, then the address low byte (bits 7..0).
- R3: A read of N bytes delivers exactly N bytes on `rdData`, in ascending address order, inside one chip-select window. While `rdValid` is high and `rdReady` is low, `rdValid` and `rdData` hold.
- R4: Each write transaction (instruction 0x02 plus two address bytes) is preceded by its own transaction carrying only instruction 0x06, with `csN` returning high between the two.
- R5: Write payload is taken from the write stream in order, and `wrReady` is high only while `csN` is low. No write transaction spans a 64-byte page boundary, so a request touching k+1 pages uses exactly k+1 write transactions.
- R6: After each write transaction the sequencer sends instruction 0x05 followed by one dummy frame. It repeats this while bit 0 of the returned status is 1 (device busy). It issues no other instruction while the device is busy, and a write request signals done only after the device reports ready.
- R7: `cmdOp` 2 or 3 requests status: one transaction of 0x05 plus one dummy frame, with the received byte delivered on the read stream.
- R8: Before every falling edge of `csN`, including the first after reset, `csN` has been high for at least `CS_GAP` clock cycles.
- R9: `done` is a single-cycle pulse, one per request. `busy` is high from the cycle after acceptance until `done`. `cmdReady` is high only when `busy` is low and `rdValid` is low.
- R10: Out of reset: `csN`=1, `sclk`=0, `busy`=0, `done`=0, `rdValid`=0, `wrReady`=0 and `cmdReady`=1.
- R11: A read or write request with `cmdLen`=0 (`cmdOp` 0 = read, 1 = write) raises `done` in the following cycle. It does not assert `csN` and does not raise `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Request present |
| cmdReady | output | 1 | Request accepted when high together with cmdValid |
| cmdOp | input | 2 | 0 read, 1 write, 2 or 3 status |
| cmdAddr | input | ADDR_W | Start byte address |
| cmdLen | input | LEN_W | Number of payload bytes |
| wrData | input | 8 | Write payload byte |
| wrValid | input | 1 | Write payload byte present |
| wrReady | output | 1 | Write payload byte taken |
| rdData | output | 8 | Read payload or status byte |
| rdValid | output | 1 | Read byte present |
| rdReady | input | 1 | Read byte taken |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| csN | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data from the device |

## Verification
A bad address counter shows up in the address frames of the next transaction, or as payload landing on the wrong page. In either case the data read back differs within one frame time. A stale page-edge or remaining-length decision gives the wrong number of write transactions or a wrong byte count on the read stream, and the device model detects this when chip select next rises. A lost busy-bit capture makes the sequencer report done while the device model is still programming, or send an instruction that the model flags as arriving during its busy window. A gap counter that does not reload shows up at the very next chip-select fall.

// File: rtl/spi_rom_pkg.sv
package spi_rom_pkg;

  localparam logic [7:0] INS_READ  = 8'h03;
  localparam logic [7:0] INS_WRITE = 8'h02;
  localparam logic [7:0] INS_WREN  = 8'h06;
  localparam logic [7:0] INS_STAT  = 8'h05;

  typedef enum logic [2:0] {
    TX_INSTR, TX_ADDR_HI, TX_ADDR_LO, TX_DATA, TX_DUMMY
  } txSel_t;

  typedef enum logic [2:0] {
    K_READ, K_STAT, K_WREN, K_WRITE, K_POLL
  } xferKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       latchCmd;
    logic       csDrop;
    logic       csRaise;
    logic       send;
    txSel_t     txSel;
    logic [7:0] instr;
    logic       step;
    logic       rdPush;
  } dpCtl_t;

  function automatic logic [7:0] instrOf(xferKind_t k);
    case (k)
      K_READ:  return INS_READ;
      K_WRITE: return INS_WRITE;
      K_WREN:  return INS_WREN;
      default: return INS_STAT;
    endcase
  endfunction

endpackage

// File: rtl/spi_rom_dp.sv
module spi_rom_dp
  import spi_rom_pkg::*;
#(
  parameter int ADDR_W     = 14,
  parameter int LEN_W      = 16,
  parameter int PAGE_BYTES = 64,
  parameter int CS_GAP     = 4,
  parameter int HALF_CYC   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [LEN_W-1:0]  cmdLen,
  input  logic [7:0]        wrData,
  input  logic              rdReady,
  input  logic              miso,
  output logic              csN,
  output logic              sclk,
  output logic              mosi,
  output logic [7:0]        rdData,
  output logic              rdValid,
  output logic              gapOk,
  output logic              byteDone,
  output logic              remZero,
  output logic              pageEdge,
  output logic              rxBit0
);

  localparam int PAGE_W = $clog2(PAGE_BYTES);
  localparam int GAP_W  = $clog2(CS_GAP + 1);
  localparam int DIV_W  = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic [ADDR_W-1:0] curAddr;
  logic [LEN_W-1:0]  remLen;
  logic [GAP_W-1:0]  gapCnt;
  logic [DIV_W-1:0]  divCnt;
  logic [2:0]        bitCnt;
  logic              active;
  logic [7:0]        shTx, shRx, txByte;
  logic [15:0]       addr16;

  assign addr16 = 16'(curAddr);

  always_comb begin
    case (ctl.txSel)
      TX_INSTR:   txByte = ctl.instr;
      TX_ADDR_HI: txByte = addr16[15:8];
      TX_ADDR_LO: txByte = addr16[7:0];
      TX_DATA:    txByte = wrData;
      default:    txByte = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr  <= '0;
      remLen   <= '0;
      csN      <= 1'b1;
      gapCnt   <= GAP_W'(CS_GAP);
      divCnt   <= '0;
      bitCnt   <= '0;
      active   <= 1'b0;
      sclk     <= 1'b0;
      shTx     <= '0;
      shRx     <= '0;
      byteDone <= 1'b0;
      rdData   <= '0;
      rdValid  <= 1'b0;
    end else begin
      byteDone <= 1'b0;
      if (ctl.latchCmd) begin
        curAddr <= cmdAddr;
        remLen  <= cmdLen;
      end else if (ctl.step) begin
        curAddr <= curAddr + 1'b1;
        remLen  <= remLen - 1'b1;
      end
      if (ctl.csDrop) csN <= 1'b0;
      if (ctl.csRaise) begin
        csN    <= 1'b1;
        gapCnt <= GAP_W'(CS_GAP);
      end else if (gapCnt != '0) begin
        gapCnt <= gapCnt - 1'b1;
      end
      if (ctl.send) begin
        active <= 1'b1;
        shTx   <= txByte;
        sclk   <= 1'b0;
        divCnt <= DIV_W'(HALF_CYC - 1);
        bitCnt <= '0;
      end else if (active) begin
        if (divCnt != '0) begin
          divCnt <= divCnt - 1'b1;
        end else begin
          divCnt <= DIV_W'(HALF_CYC - 1);
          if (!sclk) begin
            sclk <= 1'b1;
            shRx <= {shRx[6:0], miso};
          end else begin
            sclk <= 1'b0;
            if (bitCnt == 3'd7) begin
              active   <= 1'b0;
              byteDone <= 1'b1;
            end else begin
              bitCnt <= bitCnt + 1'b1;
              shTx   <= {shTx[6:0], 1'b0};
            end
          end
        end
      end
      if (ctl.rdPush) begin
        rdData  <= shRx;
        rdValid <= 1'b1;
      end else if (rdValid && rdReady) begin
        rdValid <= 1'b0;
      end
    end
  end

  assign mosi     = shTx[7];
  assign gapOk    = (gapCnt == '0);
  assign remZero  = (remLen == '0);
  assign pageEdge = (curAddr[PAGE_W-1:0] == '0);
  assign rxBit0   = shRx[0];

endmodule

// File: rtl/spi_rom_ctrl.sv
module spi_rom_ctrl
  import spi_rom_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  input  logic       lenZero,
  input  logic       wrValid,
  input  logic       rdValid,
  input  logic       gapOk,
  input  logic       byteDone,
  input  logic       remZero,
  input  logic       pageEdge,
  input  logic       rxBit0,
  output logic       cmdReady,
  output logic       wrReady,
  output logic       busy,
  output logic       done,
  output dpCtl_t     ctl
);

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_BYTE, S_RDWAIT, S_WRWAIT, S_END
  } state_t;

  state_t    state, stN;
  xferKind_t kind, kN;
  logic [1:0] idx, iN;
  logic       pollBusy, pbN, doneN;

  assign cmdReady = (state == S_IDLE) && !rdValid;
  assign wrReady  = (state == S_WRWAIT);
  assign busy     = (state != S_IDLE);

  always_comb begin
    ctl       = '0;
    ctl.instr = instrOf(kind);
    stN = state; kN = kind; iN = idx; pbN = pollBusy; doneN = 1'b0;
    case (state)
      S_IDLE: if (cmdValid && cmdReady) begin
        if (cmdOp[1]) begin
          ctl.latchCmd = 1'b1; kN = K_STAT; stN = S_START;
        end else if (lenZero) begin
          doneN = 1'b1;
        end else begin
          ctl.latchCmd = 1'b1;
          kN  = cmdOp[0] ? K_WREN : K_READ;
          stN = S_START;
        end
      end
      S_START: if (gapOk) begin
        ctl.csDrop = 1'b1; ctl.send = 1'b1; ctl.txSel = TX_INSTR;
        iN = 2'd0; stN = S_BYTE;
      end
      S_BYTE: if (byteDone) begin
        case (kind)
          K_WREN: stN = S_END;
          K_STAT, K_POLL: begin
            if (idx == 2'd0) begin
              ctl.send = 1'b1; ctl.txSel = TX_DUMMY; iN = 2'd1;
            end else begin
              if (kind == K_STAT) ctl.rdPush = 1'b1;
              else pbN = rxBit0;
              stN = S_END;
            end
          end
          default: begin  // K_READ, K_WRITE
            case (idx)
              2'd0: begin ctl.send = 1'b1; ctl.txSel = TX_ADDR_HI; iN = 2'd1; end
              2'd1: begin ctl.send = 1'b1; ctl.txSel = TX_ADDR_LO; iN = 2'd2; end
              2'd2: begin
                iN = 2'd3;
                if (kind == K_READ) begin
                  ctl.send = 1'b1; ctl.txSel = TX_DUMMY; ctl.step = 1'b1;
                end else begin
                  stN = S_WRWAIT;
                end
              end
              default: begin
                if (kind == K_READ) begin
                  ctl.rdPush = 1'b1;
                  stN = remZero ? S_END : S_RDWAIT;
                end else begin
                  stN = (remZero || pageEdge) ? S_END : S_WRWAIT;
                end
              end
            endcase
          end
        endcase
      end
      S_RDWAIT: if (!rdValid) begin
        ctl.send = 1'b1; ctl.txSel = TX_DUMMY; ctl.step = 1'b1; stN = S_BYTE;
      end
      S_WRWAIT: if (wrValid) begin
        ctl.send = 1'b1; ctl.txSel = TX_DATA; ctl.step = 1'b1; stN = S_BYTE;
      end
      S_END: begin
        ctl.csRaise = 1'b1;
        case (kind)
          K_WREN:  begin kN = K_WRITE; stN = S_START; end
          K_WRITE: begin kN = K_POLL;  stN = S_START; end
          K_POLL: begin
            if (pollBusy)     stN = S_START;
            else if (remZero) begin stN = S_IDLE; doneN = 1'b1; end
            else begin kN = K_WREN; stN = S_START; end
          end
          default: begin stN = S_IDLE; doneN = 1'b1; end
        endcase
      end
      default: stN = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      kind     <= K_STAT;
      idx      <= '0;
      pollBusy <= 1'b0;
      done     <= 1'b0;
    end else begin
      state    <= stN;
      kind     <= kN;
      idx      <= iN;
      pollBusy <= pbN;
      done     <= doneN;
    end
  end

endmodule

// File: rtl/spi_rom_cmd_seq.sv
module spi_rom_cmd_seq
  import spi_rom_pkg::*;
#(
  parameter int ADDR_W     = 14,
  parameter int LEN_W      = 16,
  parameter int PAGE_BYTES = 64,
  parameter int CS_GAP     = 4,
  parameter int HALF_CYC   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [1:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [LEN_W-1:0]  cmdLen,
  input  logic [7:0]        wrData,
  input  logic              wrValid,
  output logic              wrReady,
  output logic [7:0]        rdData,
  output logic              rdValid,
  input  logic              rdReady,
  output logic              busy,
  output logic              done,
  output logic              csN,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);

  dpCtl_t ctl;
  logic gapOk, byteDone, remZero, pageEdge, rxBit0;

  spi_rom_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .lenZero(cmdLen == '0), .wrValid(wrValid), .rdValid(rdValid),
    .gapOk(gapOk), .byteDone(byteDone), .remZero(remZero),
    .pageEdge(pageEdge), .rxBit0(rxBit0), .cmdReady(cmdReady),
    .wrReady(wrReady), .busy(busy), .done(done), .ctl(ctl)
  );

  spi_rom_dp #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES),
    .CS_GAP(CS_GAP), .HALF_CYC(HALF_CYC)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cmdAddr(cmdAddr), .cmdLen(cmdLen),
    .wrData(wrData), .rdReady(rdReady), .miso(miso), .csN(csN),
    .sclk(sclk), .mosi(mosi), .rdData(rdData), .rdValid(rdValid),
    .gapOk(gapOk), .byteDone(byteDone), .remZero(remZero),
    .pageEdge(pageEdge), .rxBit0(rxBit0)
  );

endmodule

// File: rtl/spi_rom_cmd_seq_chk.sv
module spi_rom_cmd_seq_chk #(
  parameter int CS_GAP = 4
) (
  input logic       clk,
  input logic       rstN,
  input logic       csN,
  input logic       sclk,
  input logic       mosi,
  input logic [7:0] rdData,
  input logic       rdValid,
  input logic       rdReady,
  input logic       done,
  input logic       busy,
  input logic       cmdReady,
  input logic       wrReady
);

  logic [15:0] highCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) highCnt <= '0;
    else if (!csN) highCnt <= '0;
    else if (highCnt != 16'hFFFF) highCnt <= highCnt + 1'b1;
  end

  a_r1_sclk_idle: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);

  a_r1_mosi_hold: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && $past(sclk)) |-> $stable(mosi));

  a_r3_rd_hold: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !rdReady) |=> (rdValid && $stable(rdData)));

  a_r5_wr_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    wrReady |-> !csN);

  a_r8_cs_gap: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> (highCnt >= 16'(CS_GAP)));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r9_ready_idle: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |-> (!busy && !rdValid));

endmodule

bind spi_rom_cmd_seq spi_rom_cmd_seq_chk #(.CS_GAP(CS_GAP)) chk_i (
  .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .mosi(mosi),
  .rdData(rdData), .rdValid(rdValid), .rdReady(rdReady), .done(done),
  .busy(busy), .cmdReady(cmdReady), .wrReady(wrReady)
);

// File: tb/spi_rom_cmd_seq_tb_top.sv
module spi_rom_cmd_seq_tb_top;

  localparam int ADDR_W = 14, LEN_W = 16, CS_GAP = 4, HALF_CYC = 2;
  localparam int BUSY_CLKS = 150;
  localparam int AMASK = (1 << ADDR_W) - 1;

  logic clk = 1'b0, rstN = 1'b0;
  logic cmdValid = 1'b0, cmdReady;
  logic [1:0] cmdOp = '0;
  logic [ADDR_W-1:0] cmdAddr = '0;
  logic [LEN_W-1:0] cmdLen = '0;
  logic [7:0] wrData = '0, rdData;
  logic wrValid = 1'b0, wrReady, rdValid, rdReady = 1'b0;
  logic busy, done, csN, sclk, mosi, miso = 1'b0;

  spi_rom_cmd_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CS_GAP(CS_GAP),
                    .HALF_CYC(HALF_CYC)) dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdOp(cmdOp), .cmdAddr(cmdAddr), .cmdLen(cmdLen), .wrData(wrData),
    .wrValid(wrValid), .wrReady(wrReady), .rdData(rdData),
    .rdValid(rdValid), .rdReady(rdReady), .busy(busy), .done(done),
    .csN(csN), .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  initial forever #4 clk = ~clk;  // 125 MHz

  int checks = 0, errors = 0;
  int cyc = 0, doneCnt = 0, csFallCnt = 0, wrInstrCnt = 0, pollCnt = 0;
  logic [7:0] mem[int];
  logic [7:0] shadow[int];
  logic [7:0] wrQ[$];
  logic [7:0] expQ[$];
  string      tagQ[$];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] rdMem(int a);
    return mem.exists(a) ? mem[a] : 8'hFF;
  endfunction
  function automatic logic [7:0] rdShadow(int a);
    return shadow.exists(a) ? shadow[a] : 8'hFF;
  endfunction

  // device model: mode 0 slave with page wrap and a self-timed busy window
  int bitN = 0, byteN = 0, sAddr = 0, wrBase = 0, sBusy = 0, csHigh = 0;
  logic prevCs = 1'b1, prevSclk = 1'b0, wel = 1'b0;
  logic [7:0] inSh = '0, outByte = '0, instr = '0;
  logic [7:0] wq[$];

  initial forever begin
    @(negedge clk);
    cyc++;
    if (sBusy > 0) sBusy--;
    chk(!(csN && sclk), "R1", "sclk while deselected", sclk, 0);
    if (!csN && prevCs) begin
      csFallCnt++;
      chk(csHigh >= CS_GAP, "R8", "chip-select gap", csHigh, CS_GAP);
      bitN = 0; byteN = 0; instr = 8'h00; outByte = 8'h00; wq.delete();
    end
    if (csN && !prevCs) begin
      if (instr == 8'h06) wel = 1'b1;
      if (instr == 8'h02 && wel && wq.size() > 0) begin
        chk((wrBase % 64) + wq.size() <= 64, "R5", "page span",
            (wrBase % 64) + wq.size(), 64);
        foreach (wq[i]) mem[(wrBase & ~63) | ((wrBase + i) & 63)] = wq[i];
        sBusy = BUSY_CLKS;
        wel = 1'b0;
      end
    end
    csHigh = csN ? csHigh + 1 : 0;
    if (!csN && sclk && !prevSclk) begin
      inSh = {inSh[6:0], mosi};
      bitN++;
      if (bitN == 8) begin
        bitN = 0;
        if (byteN == 0) begin
          chk(sBusy == 0 || inSh == 8'h05, "R6", "instruction during write cycle",
              inSh, 8'h05);
          chk(inSh inside {8'h02, 8'h03, 8'h05, 8'h06}, "R2", "instruction code",
              inSh, 8'h03);
          instr = (sBusy > 0 && inSh != 8'h05) ? 8'hFF : inSh;
          if (instr == 8'h02) begin
            wrInstrCnt++;
            chk(wel, "R4", "write without enable", wel, 1);
          end
          if (instr == 8'h05) begin
            pollCnt++;
            outByte = {6'b0, wel, sBusy > 0};
          end
        end else if (instr == 8'h02 || instr == 8'h03) begin
          if (byteN == 1) begin
            chk(inSh[7:6] == 2'b00, "R2", "address high bits", inSh[7:6], 0);
            sAddr = int'(inSh[5:0]) << 8;
          end else if (byteN == 2) begin
            sAddr = sAddr | int'(inSh);
            wrBase = sAddr;
            if (instr == 8'h03) outByte = rdMem(sAddr);
          end else if (instr == 8'h03) begin
            sAddr = (sAddr + 1) & AMASK;
            outByte = rdMem(sAddr);
          end else begin
            wq.push_back(inSh);
          end
        end
        byteN++;
      end
    end
    miso = csN ? 1'b0 : outByte[7 - bitN];
    prevCs = csN;
    prevSclk = sclk;
    if (done) doneCnt++;
  end

  // write stream source with idle gaps
  initial forever begin
    @(negedge clk);
    wrValid = (wrQ.size() > 0) && (cyc % 5 != 0);
    wrData  = (wrQ.size() > 0) ? wrQ[0] : 8'h00;
    if (wrValid && wrReady) void'(wrQ.pop_front());
  end

  // read stream sink with backpressure
  initial forever begin
    @(negedge clk);
    rdReady = (cyc % 3 != 1);
    if (rdValid && rdReady) begin
      if (expQ.size() > 0) begin
        chk(rdData == expQ[0], tagQ[0], "read stream byte", rdData, expQ[0]);
        void'(expQ.pop_front());
        void'(tagQ.pop_front());
      end else begin
        chk(0, "R3", "unexpected read byte", rdData, 0);
      end
    end
  end

  function automatic int segCount(int a, int n);
    int s = 0;
    for (int i = 0; i < n; i++)
      if (i == 0 || (((a + i) & AMASK) % 64) == 0) s++;
    return s;
  endfunction

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic runCmd(int op, int addr, int len);
    int d0, w0, c0, segs, t;
    if (op == 1) begin
      for (int i = 0; i < len; i++) begin
        logic [7:0] v;
        v = 8'((addr * 3 + i * 37 + 5) & 255);
        wrQ.push_back(v);
        shadow[(addr + i) & AMASK] = v;
      end
    end else if (op == 0) begin
      for (int i = 0; i < len; i++) begin
        expQ.push_back(rdShadow((addr + i) & AMASK));
        tagQ.push_back("R3");
      end
    end else begin
      expQ.push_back(8'h00);
      tagQ.push_back("R7");
    end
    d0 = doneCnt; w0 = wrInstrCnt; c0 = csFallCnt;
    segs = segCount(addr, len);
    cmdOp = 2'(op); cmdAddr = ADDR_W'(addr); cmdLen = LEN_W'(len);
    cmdValid = 1'b1;
    while (!cmdReady) @(negedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
    if (op != 2 && len == 0) begin
      chk(done && !busy, "R11", "zero-length done", done, 1);
    end else begin
      chk(busy, "R9", "busy after accept", busy, 1);
    end
    t = 0;
    while (doneCnt == d0 && t < 20000) begin @(negedge clk); t++; end
    chk(doneCnt == d0 + 1, "R9", "done pulse count", doneCnt - d0, 1);
    chk(!busy, "R9", "busy at done", busy, 0);
    if (op == 1 && len > 0) begin
      chk(wrInstrCnt - w0 == segs, "R5", "write transactions", wrInstrCnt - w0, segs);
      chk(sBusy == 0, "R6", "done while device busy", sBusy, 0);
      chk(wrQ.size() == 0, "R5", "write bytes left", wrQ.size(), 0);
    end
    if (len == 0 && op != 2)
      chk(csFallCnt == c0, "R11", "chip select activity", csFallCnt - c0, 0);
    t = 0;
    while (expQ.size() > 0 && t < 2000) begin @(negedge clk); t++; end
    chk(expQ.size() == 0, "R3", "read bytes missing", expQ.size(), 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "WD", "watchdog expired", cyc, 0);
    finishRun();
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(csN == 1'b1, "R10", "csN after reset", csN, 1);
    chk(sclk == 1'b0, "R10", "sclk after reset", sclk, 0);
    chk(!busy && !done, "R10", "busy/done after reset", {busy, done}, 0);
    chk(!rdValid && !wrReady, "R10", "streams after reset", {rdValid, wrReady}, 0);
    chk(cmdReady, "R10", "cmdReady after reset", cmdReady, 1);
    runCmd(2, 0, 1);           // R7 status at rest
    runCmd(1, 'h0010, 4);      // R4 R5 R6 one page
    runCmd(0, 'h0010, 4);      // R2 R3
    runCmd(1, 'h003A, 10);     // R5 split across a page edge
    runCmd(0, 'h0038, 12);     // R3 read across a page edge
    runCmd(0, 'h0100, 0);      // R11 zero-length read
    runCmd(1, 'h0200, 0);      // R11 zero-length write
    runCmd(1, 'h3FE0, 70);     // R5 split at top of address space
    runCmd(0, 'h3FE0, 70);     // R3 wrapping read
    runCmd(1, 'h007F, 1);      // R5 last byte of a page
    runCmd(0, 'h007E, 3);
    runCmd(3, 0, 1);           // R7 alternate status code
    chk(pollCnt > 8, "R6", "status polls issued", pollCnt, 9);
    finishRun();
  end

endmodule